// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target with a 7-bit address. The address comes from an input port. Behind the bus it holds two groups of byte registers. The data group has eight entries at pointer values 0 to 7. The system group has four entries at pointer values 0x20 to 0x23. A controller selects a register by writing one pointer byte. It then streams bytes into or out of the block, and the pointer advances after every transferred byte.

The local side of the chip has three ports. It can write any data register, read any data register, and write any system register. A typical use is sensor logic that refreshes the data group while a remote controller reads it. Firmware values, such as a version code or a configured delay, are loaded into the system group through the local system write port.

Both bus lines are sampled through two-flop synchronizers. SDA is released or pulled low through an open-drain enable. The block never holds SCL.

Top module: `i2c_regptr_target`

## Requirements
- R1: An address byte (7-bit address, then the R/W bit in the LSB, 1 = read) whose address differs from `dev_addr` is not acknowledged. The block ignores the rest of that transfer, and no register or pointer changes.
- R2: A matching write address is acknowledged (SDA low on the ninth clock) and sets the pointer to the unset value 0xFF. While the pointer is unset, the next written byte becomes the pointer. That byte is acknowledged only if it is in 0..7 or 0x20..0x23. Otherwise it is not acknowledged, and the block ignores further bytes until the next START.
- R3: With a valid pointer, each written byte is stored in the selected data register (0..7) or system register (0x20 + n). The pointer then increments and the byte is acknowledged.
- R4: A written byte that arrives while the pointer is outside both windows (for example 8 or 0x24) is not acknowledged and stores nothing.
- R5: On a matching read address, an unset pointer becomes 0. Each transmitted byte is the selected register's value at the moment that byte starts, most significant bit first. The pointer increments after each byte.
- R6: A read address is not acknowledged when the pointer lies outside both windows. During a read, if the pointer steps outside the windows after a controller ACK, SDA stays released (the controller sees 0xFF) and the block returns to listening for START.
- R7: A STOP returns the block to idle with SDA released and the pointer kept. A later read, whether after STOP or after a repeated START, continues from the kept pointer.
- R8: A controller NACK after a read byte releases SDA and ends the transfer. The next START is handled normally.
- R9: The local data write port, data read port and system write port act on the same registers the bus uses. A bus write is visible on the local data read port.
- R10: SDA is pulled low only in the address ACK slot, the data ACK slot and the transmit bit slots. START and STOP are recognised as SDA edges while SCL is high.
- R11: After reset, SDA is released, all registers read 0 and the pointer is unset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Target address on the bus |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| dat_we | input | 1 | Local data register write strobe |
| dat_widx | input | 3 | Local data register write index |
| dat_wdata | input | 8 | Local data register write value |
| dat_ridx | input | 3 | Local data register read index |
| dat_rdata | output | 8 | Local data register read value |
| sys_we | input | 1 | Local system register write strobe |
| sys_widx | input | 2 | Local system register write index |
| sys_wdata | input | 8 | Local system register write value |

## Verification
The hardest cases to reach are the pointer running off the end of a window in the middle of a read, and the snapshot taken at the start of a transmitted byte. Both require the pointer to be placed exactly beforehand with a separate pointer-only write. The bench then drives a multi-byte read that starts at 0x22, so the third byte finds the pointer at 0x24. For the snapshot, a forked process rewrites a data register through the local port three bits into the byte that is carrying it. A behavioural model of the pointer and the registers predicts every ACK bit and read byte. A per-clock monitor flags SDA being pulled low outside the slots where the target may drive.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  localparam int DW = 8;
  localparam int DAT_N = 8;
  localparam int SYS_N = 4;
  localparam int DAT_IW = $clog2(DAT_N);
  localparam int SYS_IW = $clog2(SYS_N);
  localparam logic [7:0] SYS_BASE = 8'h20;
  localparam logic [7:0] PTR_NONE = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK
  } st_t;

  function automatic logic is_dat(input logic [7:0] p);
    return p < 8'(DAT_N);
  endfunction

  function automatic logic is_sys(input logic [7:0] p);
    return (p >= SYS_BASE) && (p < SYS_BASE + 8'(SYS_N));
  endfunction

  function automatic logic ptr_ok(input logic [7:0] p);
    return is_dat(p) || is_sys(p);
  endfunction
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], raw[g]};
    end
    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
    assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/i2c_rp_regs.sv
module i2c_rp_regs
  import i2c_rp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [7:0]        bus_ptr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [7:0]        rd_ptr,
  output logic [DW-1:0]     rd_data,
  input  logic              dat_we,
  input  logic [DAT_IW-1:0] dat_widx,
  input  logic [DW-1:0]     dat_wdata,
  input  logic [DAT_IW-1:0] dat_ridx,
  output logic [DW-1:0]     dat_rdata,
  input  logic              sys_we,
  input  logic [SYS_IW-1:0] sys_widx,
  input  logic [DW-1:0]     sys_wdata
);
  logic [DAT_N*DW-1:0] dat_flat;
  logic [SYS_N*DW-1:0] sys_flat;

  // local port wins when both sides hit the same register in one cycle
  for (genvar i = 0; i < DAT_N; i++) begin : g_dat
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= '0;
      else if (dat_we && dat_widx == DAT_IW'(i))   q <= dat_wdata;
      else if (bus_we && bus_ptr == 8'(i))         q <= bus_wdata;
    end
    assign dat_flat[i*DW +: DW] = q;
  end

  for (genvar i = 0; i < SYS_N; i++) begin : g_sys
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     q <= '0;
      else if (sys_we && sys_widx == SYS_IW'(i))      q <= sys_wdata;
      else if (bus_we && bus_ptr == SYS_BASE + 8'(i)) q <= bus_wdata;
    end
    assign sys_flat[i*DW +: DW] = q;
  end

  logic [DAT_IW-1:0] rd_di;
  logic [SYS_IW-1:0] rd_si;
  assign rd_di = DAT_IW'(rd_ptr);
  assign rd_si = SYS_IW'(rd_ptr - SYS_BASE);

  always_comb begin
    if (is_dat(rd_ptr))      rd_data = dat_flat[rd_di*DW +: DW];
    else if (is_sys(rd_ptr)) rd_data = sys_flat[rd_si*DW +: DW];
    else                     rd_data = '1;
  end

  assign dat_rdata = dat_flat[dat_ridx*DW +: DW];
endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
  import i2c_rp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    dev_addr,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic [DW-1:0] rd_data,
  output logic [7:0]    ptr,
  output st_t           st,
  output logic          sda_oe,
  output logic          bus_we,
  output logic [7:0]    bus_ptr,
  output logic [DW-1:0] bus_wdata,
  output logic          start_evt,
  output logic          stop_evt,
  output logic          addr_wr_hit
);
  logic [7:0]    sh;
  logic [DW-1:0] tx;
  logic [3:0]    cnt;
  logic          rw;
  logic          mack;
  logic          byte_done;
  logic          addr_match;
  logic [7:0]    rd_start;

  assign start_evt  = sda_fall & scl_lvl;
  assign stop_evt   = sda_rise & scl_lvl;
  assign byte_done  = scl_fall && (cnt == 4'd8);
  assign addr_match = (sh[7:1] == dev_addr);
  assign rd_start   = (ptr == PTR_NONE) ? 8'h00 : ptr;
  assign addr_wr_hit = (st == ST_ADDR) && byte_done && addr_match && !sh[0];
  assign bus_we     = (st == ST_RX) && byte_done && (ptr != PTR_NONE) && ptr_ok(ptr);
  assign bus_ptr    = ptr;
  assign bus_wdata  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ptr    <= PTR_NONE;
      sh     <= '0;
      tx     <= '0;
      cnt    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      st     <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_lvl};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (!addr_match) begin
                st <= ST_IDLE;
              end else if (!sh[0]) begin
                ptr <= PTR_NONE; rw <= 1'b0; st <= ST_AACK; sda_oe <= 1'b1;
              end else if (ptr_ok(rd_start)) begin
                ptr <= rd_start; rw <= 1'b1; st <= ST_AACK; sda_oe <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end else if (ptr == PTR_NONE) begin
              if (ptr_ok(sh)) begin
                ptr <= sh; st <= ST_RACK; sda_oe <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end else if (ptr_ok(ptr)) begin
              ptr <= ptr + 8'd1; st <= ST_RACK; sda_oe <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx <= rd_data; ptr <= ptr + 8'd1; st <= ST_TX; sda_oe <= ~rd_data[DW-1];
            end else begin
              st <= ST_RX; sda_oe <= 1'b0;
            end
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            st <= ST_RX; sda_oe <= 1'b0;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              st <= ST_TACK; sda_oe <= 1'b0;
            end else begin
              tx <= {tx[DW-2:0], 1'b0}; sda_oe <= ~tx[DW-2];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            mack <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack && ptr_ok(ptr)) begin
              tx <= rd_data; ptr <= ptr + 8'd1; cnt <= '0;
              st <= ST_TX; sda_oe <= ~rd_data[DW-1];
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
  import i2c_rp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        dev_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              dat_we,
  input  logic [DAT_IW-1:0] dat_widx,
  input  logic [DW-1:0]     dat_wdata,
  input  logic [DAT_IW-1:0] dat_ridx,
  output logic [DW-1:0]     dat_rdata,
  input  logic              sys_we,
  input  logic [SYS_IW-1:0] sys_widx,
  input  logic [DW-1:0]     sys_wdata
);
  logic [1:0] ln_lvl, ln_rise, ln_fall;
  logic [7:0]    ptr;
  st_t           st;
  logic          bus_we;
  logic [7:0]    bus_ptr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] rd_data;
  logic          start_evt, stop_evt, addr_wr_hit;

  i2c_rp_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({sda_i, scl_i}),
    .lvl(ln_lvl), .rise(ln_rise), .fall(ln_fall)
  );

  i2c_rp_engine u_eng (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
    .scl_lvl(ln_lvl[0]), .sda_lvl(ln_lvl[1]),
    .scl_rise(ln_rise[0]), .scl_fall(ln_fall[0]),
    .sda_rise(ln_rise[1]), .sda_fall(ln_fall[1]),
    .rd_data(rd_data), .ptr(ptr), .st(st), .sda_oe(sda_oe),
    .bus_we(bus_we), .bus_ptr(bus_ptr), .bus_wdata(bus_wdata),
    .start_evt(start_evt), .stop_evt(stop_evt), .addr_wr_hit(addr_wr_hit)
  );

  i2c_rp_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_ptr(bus_ptr), .bus_wdata(bus_wdata),
    .rd_ptr(ptr), .rd_data(rd_data),
    .dat_we(dat_we), .dat_widx(dat_widx), .dat_wdata(dat_wdata),
    .dat_ridx(dat_ridx), .dat_rdata(dat_rdata),
    .sys_we(sys_we), .sys_widx(sys_widx), .sys_wdata(sys_wdata)
  );
endmodule

// File: rtl/i2c_rp_chk.sv
module i2c_rp_chk
  import i2c_rp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input st_t        st,
  input logic [7:0] ptr,
  input logic       sda_oe,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       addr_wr_hit,
  input logic       bus_we,
  input logic [7:0] bus_ptr
);
  p_sentinel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr_hit |=> ptr == PTR_NONE);

  p_wr_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (st == ST_RACK) && sda_oe);

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> ptr == $past(bus_ptr) + 8'd1);

  p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (st == ST_IDLE) && !sda_oe);

  p_stop_keeps_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> ptr == $past(ptr));

  p_start_listen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> st == ST_ADDR);

  p_drive_slots_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == ST_AACK || st == ST_RACK || st == ST_TX));
endmodule

bind i2c_regptr_target i2c_rp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .ptr(ptr), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .addr_wr_hit(addr_wr_hit),
  .bus_we(bus_we), .bus_ptr(bus_ptr)
);

// File: tb/i2c_regptr_target_tb.sv
module i2c_regptr_target_tb;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] dev_addr = 7'h2F;
  logic       scl_c = 1'b1, sda_c = 1'b1;
  logic       sda_oe;
  wire        sda_bus = sda_c & ~sda_oe;
  logic       dat_we = 1'b0, sys_we = 1'b0;
  logic [2:0] dat_widx = '0, dat_ridx = '0;
  logic [1:0] sys_widx = '0;
  logic [7:0] dat_wdata = '0, sys_wdata = '0, dat_rdata;

  always #10 clk = ~clk;

  i2c_regptr_target u_dut (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .scl_i(scl_c), .sda_i(sda_bus),
    .sda_oe(sda_oe), .dat_we(dat_we), .dat_widx(dat_widx), .dat_wdata(dat_wdata),
    .dat_ridx(dat_ridx), .dat_rdata(dat_rdata), .sys_we(sys_we),
    .sys_widx(sys_widx), .sys_wdata(sys_wdata)
  );

  int n_chk = 0, n_bad = 0;
  logic slot = 1'b0;
  logic done = 1'b0;

  // behavioural model
  logic [7:0] m_dat [8];
  logic [7:0] m_sys [4];
  int m_ptr = 255;

  function automatic bit m_ok(int p);
    return (p >= 0 && p < 8) || (p >= 32 && p < 36);
  endfunction
  function automatic logic [7:0] m_get(int p);
    return (p < 8) ? m_dat[p] : m_sys[p-32];
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R10: per-clock compare of target drive against the slots the model allows
  always @(negedge clk) if (rst_n && !done) begin
    n_chk++;
    if (sda_oe && !slot) begin
      n_bad++;
      $display("FAIL R10 SDA pulled low outside a target slot: actual=1 expected=0");
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start();
    sda_c = 1'b1; tick(Q); scl_c = 1'b1; tick(Q); sda_c = 1'b0; tick(Q); scl_c = 1'b0;
  endtask
  task automatic i2c_stop();
    tick(2); sda_c = 1'b0; tick(Q); scl_c = 1'b1; tick(Q); sda_c = 1'b1; tick(Q);
  endtask
  task automatic put_bit(logic b);
    sda_c = b; tick(Q); scl_c = 1'b1; tick(Q); scl_c = 1'b0;
  endtask
  task automatic get_bit(output logic b);
    sda_c = 1'b1; tick(Q); scl_c = 1'b1; tick(Q/2); b = sda_bus; tick(Q/2); scl_c = 1'b0;
  endtask

  task automatic wr_byte(logic [7:0] v, logic keep, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    slot = 1'b1;
    get_bit(b);
    ack = ~b;
    tick(6);
    slot = keep;
  endtask

  task automatic rd_byte(logic more, output logic [7:0] v);
    logic b;
    slot = 1'b1;
    for (int i = 0; i < 8; i++) begin get_bit(b); v = {v[6:0], b}; end
    tick(6);
    slot = 1'b0;
    put_bit(~more);
    slot = more;
  endtask

  task automatic wr_txn(string req, logic [6:0] a, logic [7:0] q[$], bit do_stop);
    logic ak;
    bit live;
    i2c_start();
    live = (a == dev_addr);
    wr_byte({a, 1'b0}, 1'b0, ak);
    check(req, ak, live, "write address ack");
    if (live) m_ptr = 255;
    foreach (q[i]) begin
      bit e;
      if (!live) e = 0;
      else if (m_ptr == 255) begin e = m_ok(q[i]); if (e) m_ptr = q[i]; end
      else begin
        e = m_ok(m_ptr);
        if (e) begin
          if (m_ptr < 8) m_dat[m_ptr] = q[i]; else m_sys[m_ptr-32] = q[i];
          m_ptr++;
        end
      end
      if (!e) live = 0;
      wr_byte(q[i], 1'b0, ak);
      check(req, ak, e, "write data ack");
    end
    if (do_stop) i2c_stop();
  endtask

  task automatic rd_txn(string req, logic [6:0] a, int n);
    logic ak;
    logic [7:0] v;
    bit live, e;
    i2c_start();
    live = (a == dev_addr);
    if (live && m_ptr == 255) m_ptr = 0;
    e = live && m_ok(m_ptr);
    wr_byte({a, 1'b1}, e, ak);
    check(req, ak, e, "read address ack");
    if (e) begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] x;
        if (live && m_ok(m_ptr)) begin x = m_get(m_ptr); m_ptr++; end
        else begin x = 8'hFF; live = 0; end
        rd_byte(i != n-1, v);
        check(req, v, x, "read data");
      end
    end
    slot = 1'b0;
    i2c_stop();
  endtask

  task automatic loc_dat_wr(int i, logic [7:0] v);
    dat_widx = 3'(i); dat_wdata = v; dat_we = 1'b1; tick(1); dat_we = 1'b0;
  endtask
  task automatic loc_sys_wr(int i, logic [7:0] v);
    sys_widx = 2'(i); sys_wdata = v; sys_we = 1'b1; tick(1); sys_we = 1'b0;
    m_sys[i] = v;
  endtask
  task automatic loc_dat_chk(string req, int i);
    dat_ridx = 3'(i); tick(1);
    check(req, dat_rdata, m_dat[i], "local data read");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] v;
    logic ak;
    foreach (m_dat[i]) m_dat[i] = '0;
    foreach (m_sys[i]) m_sys[i] = '0;
    tick(5); rst_n = 1'b1; tick(5);

    // R11: reset state
    check("R11", sda_oe, 0, "sda_oe after reset");
    for (int i = 0; i < 8; i++) loc_dat_chk("R11", i);

    // R9: local system write port
    loc_sys_wr(0, 8'h04); loc_sys_wr(1, 8'hA5); loc_sys_wr(2, 8'h2F); loc_sys_wr(3, 8'h20);

    // R3, R9: burst write into data group, visible locally
    q = {8'h00, 8'h11, 8'h22, 8'h33};
    wr_txn("R3", dev_addr, q, 1);
    for (int i = 0; i < 3; i++) loc_dat_chk("R9", i);

    // R4: write running past data register 7
    q = {8'h06, 8'h66, 8'h77, 8'h88};
    wr_txn("R4", dev_addr, q, 1);
    loc_dat_chk("R4", 6); loc_dat_chk("R4", 7);

    // R7, R5: pointer-only write, STOP, read system group
    q = {8'h21};
    wr_txn("R7", dev_addr, q, 1);
    rd_txn("R7", dev_addr, 2);

    // R5: address-only write leaves pointer unset, read starts at 0
    q = {};
    wr_txn("R5", dev_addr, q, 1);
    rd_txn("R5", dev_addr, 3);

    // R2: pointer byte outside both windows, later byte ignored
    q = {8'h10, 8'h44};
    wr_txn("R2", dev_addr, q, 1);
    rd_txn("R2", dev_addr, 1);

    // R1: other address on write and read
    q = {8'h00, 8'h99};
    wr_txn("R1", 7'h30, q, 1);
    rd_txn("R1", 7'h30, 1);
    rd_txn("R1", dev_addr, 1);

    // R3: bus writes into system group
    q = {8'h22, 8'hC3, 8'hD4};
    wr_txn("R3", dev_addr, q, 1);

    // R6: read address with pointer at 0x24, then read off the window end
    rd_txn("R6", dev_addr, 1);
    q = {8'h22};
    wr_txn("R6", dev_addr, q, 1);
    rd_txn("R6", dev_addr, 3);

    // R8: controller NACK ends read, next START works
    q = {8'h05};
    wr_txn("R8", dev_addr, q, 1);
    rd_txn("R8", dev_addr, 1);
    check("R8", sda_oe, 0, "sda released after NACK");
    rd_txn("R8", dev_addr, 1);

    // R7: repeated START after pointer write
    q = {8'h03};
    wr_txn("R7", dev_addr, q, 0);
    rd_txn("R7", dev_addr, 2);

    // R5: snapshot at byte start while local port rewrites the register
    q = {8'h00};
    wr_txn("R5", dev_addr, q, 1);
    i2c_start();
    wr_byte({dev_addr, 1'b1}, 1'b1, ak);
    check("R5", ak, 1, "read address ack");
    fork
      rd_byte(1'b0, v);
      begin tick(6*Q); loc_dat_wr(0, 8'h5A); end
    join
    check("R5", v, m_dat[0], "byte captured at start");
    m_dat[0] = 8'h5A; m_ptr = 1;
    slot = 1'b0;
    i2c_stop();
    q = {8'h00};
    wr_txn("R9", dev_addr, q, 1);
    rd_txn("R9", dev_addr, 2);

    check("R10", sda_oe, 0, "sda released at end");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule